// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers 36-bit words between a producer clocked by `wclk` and a consumer clocked by `rclk`. The two clocks run freely and need not be related. Storage holds 256 words. Pointers cross between the clock domains in Gray code through two-stage synchronizers. The full and almost-full flags are computed in the write domain. The empty, output-ready and almost-empty flags are computed in the read domain.

While master reset is held, two sets of choices are captured from configuration pins. The first is the handshake style. Standard timing reports full and empty, and a read presents its word one clock later. Fall-through timing reports input-ready and output-ready, and the oldest word waits on the output before any read is requested. The second choice is the offset used by both level flags. It is one of three defaults, or else it is programmed after reset. Programming is either serial, shifting 8 bits in MSB first, or parallel, with one load strobe that takes the low byte of the write bus. Until programming is complete, the FIFO accepts no writes.

A partial reset empties the FIFO and keeps the configuration. A master reset empties the FIFO and captures the configuration again from the pins.

Top module: `dcfifo_pflag`

## Requirements
- R1: The FIFO holds exactly 256 words and returns them in write order. In standard timing, `in_flag` reads 1 (full) once 256 words are stored.
- R2: In standard timing (`fwft_sel`=0 at master reset), `out_flag` is 1 while the FIFO is empty. A read accepted on an `rclk` edge places the oldest word on `rd_data` at that edge.
- R3: In fall-through timing (`fwft_sel`=1), the oldest stored word sits on `rd_data` with `out_flag`=1 without any read request, and it stays there until `rd_en` is sampled high. In this mode `in_flag`=1 means a write will be accepted.
- R4: `ofs_sel` captured at master reset selects the offset: 0 gives 8, 1 gives 16, 2 gives 64. `almost_empty` is 1 when the stored word count is at or below the offset. In fall-through timing, that count includes the word on the output. `almost_full` is 1 when the free space in storage is at or below the offset.
- R5: `ofs_sel`=3 leaves the offset to be programmed after reset. With `prog_serial`=1, each `wclk` edge with `ser_en`=1 shifts `ser_data` in MSB first, and the eighth bit completes programming. With `prog_serial`=0, one edge with `cfg_load`=1 loads `wr_data[7:0]`. Until programming completes, writes are discarded and `in_flag` shows not-ready (1 in standard timing, 0 in fall-through timing).
- R6: Master reset discards all stored words and captures timing mode and offset again from the pins.
- R7: Partial reset discards all stored words but keeps the timing mode and the offset, whatever the configuration pins show during it.
- R8: Writes and reads proceed at the same time on unrelated clocks without loss, duplication or reordering.
- R9: A write while full, or a standard-timing read while empty, is ignored. An ignored read leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, held for several cycles of both clocks |
| prst | input | 1 | Partial reset, active high, held for several cycles of both clocks |
| fwft_sel | input | 1 | Timing mode captured at master reset: 1 selects fall-through |
| ofs_sel | input | 2 | Offset choice captured at master reset (0:8, 1:16, 2:64, 3:program) |
| prog_serial | input | 1 | Programming method captured at master reset: 1 serial, 0 parallel |
| ser_data | input | 1 | Serial offset bit |
| ser_en | input | 1 | Serial shift enable |
| cfg_load | input | 1 | Parallel offset load strobe |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word, and the offset value during a parallel load |
| in_flag | output | 1 | Full (standard timing) or input-ready (fall-through timing) |
| almost_full | output | 1 | Free space at or below the offset |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read word |
| out_flag | output | 1 | Empty (standard timing) or output-ready (fall-through timing) |
| almost_empty | output | 1 | Stored count at or below the offset |

## Verification
A pointer that steps wrongly or loses a Gray transition shows at the ports as words that are missing, repeated or out of order. The level flags that change at the exact boundary counts show it too. Write-side flags react one `wclk` edge after a write. Read-side flags react within about four `rclk` edges, because of the two-stage synchronizer and the registered flag. A corrupted configuration register shows as the level flags switching at the wrong count. A lost timing mode shows as the wrong `out_flag` polarity, or as data that fails to fall through, on the first word after the reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    OFS_8    = 2'd0,
    OFS_16   = 2'd1,
    OFS_64   = 2'd2,
    OFS_PROG = 2'd3
  } ofs_choice_e;

  function automatic int dflt_ofs(input logic [1:0] s);
    case (s)
      OFS_8:   return 8;
      OFS_16:  return 16;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/dcf_gsync.sv
// Two-stage synchronizer for a Gray pointer, plus its binary value
module dcf_gsync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] gray_q,
  output logic [W-1:0] bin_q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= '0;
      gray_q <= '0;
    end else begin
      s1     <= gray_in;
      gray_q <= s1;
    end
  end

  always_comb begin
    bin_q[W-1] = gray_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_q[i] = bin_q[i+1] ^ gray_q[i];
  end
endmodule

// File: rtl/dcf_cfg.sv
// Timing mode and level offset, captured at master reset or programmed after it
module dcf_cfg
  import dcf_pkg::*;
#(
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          mode_in,
  input  logic [1:0]    sel_in,
  input  logic          ser_in,
  input  logic          ser_data,
  input  logic          ser_en,
  input  logic          load,
  input  logic [OW-1:0] load_val,
  output logic          fwft,
  output logic [OW-1:0] ofs,
  output logic          busy
);
  localparam int CW = $clog2(OW);

  logic          ser_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (mrst) begin
      fwft  <= mode_in;
      ser_q <= ser_in;
      cnt   <= '0;
      busy  <= (sel_in == OFS_PROG);
      ofs   <= (sel_in == OFS_PROG) ? '0 : OW'(dflt_ofs(sel_in));
    end else if (busy && !prst) begin
      if (ser_q) begin
        if (ser_en) begin
          ofs <= {ofs[OW-2:0], ser_data};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(OW - 1)) busy <= 1'b0;
        end
      end else if (load) begin
        ofs  <= load_val;
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcf_wside.sv
// Write pointer, full and almost-full
module dcf_wside #(
  parameter int AW = 8,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          blk,
  input  logic [AW:0]   rq_gray,
  input  logic [AW:0]   rq_bin,
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          we,
  output logic          full,
  output logic          afull
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_n, wgray_n, used, free;

  assign we      = wr_en && !full && !blk;
  assign wbin_n  = wbin + PW'(we);
  assign wgray_n = wbin_n ^ (wbin_n >> 1);
  assign used    = wbin - rq_bin;
  assign free    = PW'(DEPTH) - used;
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wgray_n;
      full  <= (wgray_n == {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});
      afull <= (free <= PW'(ofs));
    end
  end
endmodule

// File: rtl/dcf_rside.sv
// Read pointer, empty, fall-through output stage and almost-empty
module dcf_rside #(
  parameter int AW = 8,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [AW:0]   wq_gray,
  input  logic [AW:0]   wq_bin,
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          re,
  output logic          ov,
  output logic          empty,
  output logic          aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_n, rgray_n, occ;

  assign re      = fwft ? (!empty && (!ov || rd_en)) : (rd_en && !empty);
  assign rbin_n  = rbin + PW'(re);
  assign rgray_n = rbin_n ^ (rbin_n >> 1);
  assign occ     = wq_bin - rbin + PW'(fwft && ov);
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      ov     <= 1'b0;
      aempty <= 1'b1;
    end else begin
      rbin   <= rbin_n;
      rgray  <= rgray_n;
      empty  <= (rgray_n == wq_gray);
      aempty <= (occ <= PW'(ofs));
      if (re)         ov <= fwft;
      else if (rd_en) ov <= 1'b0;
    end
  end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DW = 36,
  parameter int AW = 8,
  parameter int OW = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic [1:0]    ofs_sel,
  input  logic          prog_serial,
  input  logic          ser_data,
  input  logic          ser_en,
  input  logic          cfg_load,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          in_flag,
  output logic          almost_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          out_flag,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;

  logic          fifo_rst;
  logic          cfg_fwft, cfg_busy;
  logic [OW-1:0] cfg_ofs;
  logic [AW:0]   w_gray, r_gray, rq_gray, rq_bin, wq_gray, wq_bin;
  logic [AW-1:0] waddr, raddr;
  logic          we, re, w_full, r_empty, r_ov;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  assign fifo_rst = mrst || prst;

  dcf_cfg #(.OW(OW)) u_cfg (
    .clk(wclk), .mrst(mrst), .prst(prst), .mode_in(fwft_sel), .sel_in(ofs_sel),
    .ser_in(prog_serial), .ser_data(ser_data), .ser_en(ser_en), .load(cfg_load),
    .load_val(wr_data[OW-1:0]), .fwft(cfg_fwft), .ofs(cfg_ofs), .busy(cfg_busy)
  );

  dcf_gsync #(.W(AW + 1)) u_rq (
    .clk(wclk), .rst(fifo_rst), .gray_in(r_gray), .gray_q(rq_gray), .bin_q(rq_bin)
  );

  dcf_gsync #(.W(AW + 1)) u_wq (
    .clk(rclk), .rst(fifo_rst), .gray_in(w_gray), .gray_q(wq_gray), .bin_q(wq_bin)
  );

  dcf_wside #(.AW(AW), .OW(OW)) u_w (
    .clk(wclk), .rst(fifo_rst), .wr_en(wr_en), .blk(cfg_busy), .rq_gray(rq_gray),
    .rq_bin(rq_bin), .ofs(cfg_ofs), .waddr(waddr), .wgray(w_gray), .we(we),
    .full(w_full), .afull(almost_full)
  );

  dcf_rside #(.AW(AW), .OW(OW)) u_r (
    .clk(rclk), .rst(fifo_rst), .fwft(cfg_fwft), .rd_en(rd_en), .wq_gray(wq_gray),
    .wq_bin(wq_bin), .ofs(cfg_ofs), .raddr(raddr), .rgray(r_gray), .re(re),
    .ov(r_ov), .empty(r_empty), .aempty(almost_empty)
  );

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rclk) begin
    if (re) rd_q <= mem[raddr];
  end

  assign rd_data  = rd_q;
  assign in_flag  = cfg_fwft ? !(w_full || cfg_busy) : (w_full || cfg_busy);
  assign out_flag = cfg_fwft ? r_ov : r_empty;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int DW = 36,
  parameter int AW = 8,
  parameter int OW = 8
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          in_flag,
  input logic          out_flag,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   w_gray,
  input logic [AW:0]   r_gray,
  input logic          cfg_busy,
  input logic          cfg_fwft,
  input logic [OW-1:0] cfg_ofs
);
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (mrst || prst)
    (!cfg_fwft && in_flag && wr_en) |=> $stable(w_gray)); // R9

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (mrst || prst)
    (!cfg_fwft && out_flag && rd_en) |=> $stable(r_gray)); // R9

  AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (mrst || prst)
    (cfg_fwft && out_flag && !rd_en) |=> ($stable(rd_data) && out_flag)); // R3

  AST_PROG_BLOCKS_WR: assert property (@(posedge wclk) disable iff (mrst || prst)
    cfg_busy |=> $stable(w_gray)); // R5

  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (mrst || prst)
    1'b1 |=> ($countones(w_gray ^ $past(w_gray)) <= 1)); // R8

  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (mrst || prst)
    1'b1 |=> ($countones(r_gray ^ $past(r_gray)) <= 1)); // R8

  AST_PRST_KEEPS_CFG: assert property (@(posedge wclk) disable iff (mrst)
    prst |=> ($stable(cfg_ofs) && $stable(cfg_fwft))); // R7
endmodule

bind dcfifo_pflag dcf_chk #(.DW(DW), .AW(AW), .OW(OW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .wr_en(wr_en), .rd_en(rd_en),
  .in_flag(in_flag), .out_flag(out_flag), .rd_data(rd_data), .w_gray(w_gray),
  .r_gray(r_gray), .cfg_busy(cfg_busy), .cfg_fwft(cfg_fwft), .cfg_ofs(cfg_ofs)
);

// File: tb/dcfifo_pflag_bench.sv
module dcfifo_pflag_bench;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        mrst = 1'b0, prst = 1'b0;
  logic        fwft_sel = 1'b0, prog_serial = 1'b0, ser_data = 1'b0, ser_en = 1'b0, cfg_load = 1'b0;
  logic [1:0]  ofs_sel = 2'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic        in_flag, almost_full, out_flag, almost_empty;
  logic [35:0] rd_data;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  always #2 wclk = ~wclk;   // 250 MHz
  always #3 rclk = ~rclk;   // unrelated read clock

  dcfifo_pflag u_dcfifo_pflag (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .ofs_sel(ofs_sel), .prog_serial(prog_serial), .ser_data(ser_data), .ser_en(ser_en),
    .cfg_load(cfg_load), .wr_en(wr_en), .wr_data(wr_data), .in_flag(in_flag),
    .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data), .out_flag(out_flag),
    .almost_empty(almost_empty)
  );

  typedef struct packed {
    logic       fwft;
    logic [1:0] sel;
    logic [8:0] n;
    logic       ae;
    logic       af;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 9'd8,   1'b1, 1'b0},
    '{1'b0, 2'd0, 9'd9,   1'b0, 1'b0},
    '{1'b0, 2'd1, 9'd16,  1'b1, 1'b0},
    '{1'b0, 2'd1, 9'd17,  1'b0, 1'b0},
    '{1'b0, 2'd2, 9'd64,  1'b1, 1'b0},
    '{1'b0, 2'd2, 9'd65,  1'b0, 1'b0},
    '{1'b0, 2'd0, 9'd248, 1'b0, 1'b1},
    '{1'b0, 2'd0, 9'd247, 1'b0, 1'b0},
    '{1'b0, 2'd2, 9'd192, 1'b0, 1'b1},
    '{1'b1, 2'd0, 9'd8,   1'b1, 1'b0},
    '{1'b1, 2'd0, 9'd9,   1'b0, 1'b0},
    '{1'b1, 2'd1, 9'd0,   1'b1, 1'b0}
  };

  function automatic logic [35:0] pat(input int b, input int i);
    return {4'hA, 16'(b), 16'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_mrst(input logic fw, input logic [1:0] sel, input logic ser);
    fwft_sel = fw; ofs_sel = sel; prog_serial = ser;
    @(negedge wclk) mrst = 1'b1;
    repeat (6) @(negedge wclk);
    mrst = 1'b0;
    repeat (4) @(negedge rclk);
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  task automatic push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1'b1;
      wr_data = pat(base, i);
    end
    @(negedge wclk) wr_en = 1'b0;
  endtask

  // Drain n words and count order mismatches; leaves the bench on an rclk negedge
  task automatic drain(input int n, input logic fw, input int base, output int bad);
    bad = 0;
    if (!fw) @(negedge rclk);
    for (int i = 0; i < n; i++) begin
      if (fw) begin
        if (!(out_flag && rd_data == pat(base, i))) bad++;
        rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
      end else begin
        rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
        if (rd_data != pat(base, i)) bad++;
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    logic [35:0] last;

    // Reset state, standard timing, default offset 8 (R2, R6)
    do_mrst(1'b0, 2'd0, 1'b0);
    chk(out_flag == 1'b1, "R2 empty after reset", 36'(out_flag), 36'd1);
    chk(in_flag == 1'b0, "R6 not full after reset", 36'(in_flag), 36'd0);
    chk(almost_empty == 1'b1, "R4 ae after reset", 36'(almost_empty), 36'd1);
    chk(almost_full == 1'b0, "R4 af after reset", 36'(almost_full), 36'd0);

    // Vector table: configuration and level-flag boundaries (R2, R3, R4)
    for (int v = 0; v < NV; v++) begin
      do_mrst(VEC[v].fwft, VEC[v].sel, 1'b0);
      push(int'(VEC[v].n), v);
      settle();
      chk(almost_empty == VEC[v].ae, "R4 almost_empty", 36'(almost_empty), 36'(VEC[v].ae));
      chk(almost_full == VEC[v].af, "R4 almost_full", 36'(almost_full), 36'(VEC[v].af));
      chk(in_flag == VEC[v].fwft, "R3 in_flag polarity", 36'(in_flag), 36'(VEC[v].fwft));
      if (VEC[v].fwft) begin
        chk(out_flag == (VEC[v].n != 0), "R3 output ready", 36'(out_flag), 36'(VEC[v].n != 0));
        if (VEC[v].n != 0)
          chk(rd_data == pat(v, 0), "R3 fall-through word", rd_data, pat(v, 0));
      end else begin
        chk(out_flag == (VEC[v].n == 0), "R2 empty flag", 36'(out_flag), 36'(VEC[v].n == 0));
      end
      drain(int'(VEC[v].n), VEC[v].fwft, v, bad);
      chk(bad == 0, "R1 data order", 36'(bad), 36'd0);
      chk(out_flag == VEC[v].fwft ? 1'b0 : 1'b1, "R2 drained flag", 36'(out_flag), 36'(!VEC[v].fwft));
    end

    // Full boundary and ignored overflow / underflow (R1, R9)
    do_mrst(1'b0, 2'd0, 1'b0);
    push(256, 50);
    settle();
    chk(in_flag == 1'b1, "R1 full at 256", 36'(in_flag), 36'd1);
    chk(almost_full == 1'b1, "R4 af when full", 36'(almost_full), 36'd1);
    push(1, 99);
    settle();
    drain(256, 1'b0, 50, bad);
    chk(bad == 0, "R9 overflow write ignored", 36'(bad), 36'd0);
    chk(out_flag == 1'b1, "R9 empty after 256 reads", 36'(out_flag), 36'd1);
    last = rd_data;
    rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
    @(negedge rclk);
    chk(rd_data == last, "R9 empty read ignored", rd_data, last);
    chk(out_flag == 1'b1, "R9 still empty", 36'(out_flag), 36'd1);

    // Serial programming of offset 5, writes blocked until done (R5)
    do_mrst(1'b0, 2'd3, 1'b1);
    chk(in_flag == 1'b1, "R5 not ready while programming", 36'(in_flag), 36'd1);
    push(1, 77);
    settle();
    chk(out_flag == 1'b1, "R5 write discarded while programming", 36'(out_flag), 36'd1);
    for (int b = 7; b >= 0; b--) begin
      @(negedge wclk);
      ser_en = 1'b1;
      ser_data = 8'd5 >> b;
    end
    @(negedge wclk) ser_en = 1'b0;
    chk(in_flag == 1'b0, "R5 ready after 8 serial bits", 36'(in_flag), 36'd0);
    push(5, 60);
    settle();
    chk(almost_empty == 1'b1, "R5 serial offset 5 at 5 words", 36'(almost_empty), 36'd1);
    push(1, 61);
    settle();
    chk(almost_empty == 1'b0, "R5 serial offset 5 at 6 words", 36'(almost_empty), 36'd0);
    drain(5, 1'b0, 60, bad);
    chk(bad == 0, "R5 data after programming", 36'(bad), 36'd0);
    drain(1, 1'b0, 61, bad);
    chk(bad == 0, "R5 last word", 36'(bad), 36'd0);

    // Parallel programming in fall-through mode, then partial reset (R5, R7)
    do_mrst(1'b1, 2'd3, 1'b0);
    chk(in_flag == 1'b0, "R5 fwft not ready while programming", 36'(in_flag), 36'd0);
    @(negedge wclk);
    cfg_load = 1'b1;
    wr_data = 36'd3;
    @(negedge wclk) cfg_load = 1'b0;
    chk(in_flag == 1'b1, "R5 ready after parallel load", 36'(in_flag), 36'd1);
    push(4, 70);
    settle();
    fwft_sel = 1'b0; ofs_sel = 2'd0;
    @(negedge wclk) prst = 1'b1;
    repeat (6) @(negedge wclk);
    prst = 1'b0;
    settle();
    chk(out_flag == 1'b0, "R7 data cleared, fwft kept", 36'(out_flag), 36'd0);
    chk(in_flag == 1'b1, "R7 input ready polarity kept", 36'(in_flag), 36'd1);
    push(3, 71);
    settle();
    chk(almost_empty == 1'b1, "R7 offset 3 at 3 words", 36'(almost_empty), 36'd1);
    chk(rd_data == pat(71, 0) && out_flag, "R7 first new word falls through", rd_data, pat(71, 0));
    push(1, 72);
    settle();
    chk(almost_empty == 1'b0, "R7 offset 3 kept at 4 words", 36'(almost_empty), 36'd0);

    // Master reset reloads configuration and clears data (R6)
    do_mrst(1'b0, 2'd0, 1'b0);
    chk(out_flag == 1'b1, "R6 cleared, standard timing", 36'(out_flag), 36'd1);
    push(8, 80);
    settle();
    chk(almost_empty == 1'b1, "R6 default offset 8 restored", 36'(almost_empty), 36'd1);
    drain(8, 1'b0, 80, bad);
    chk(bad == 0, "R6 only new words present", 36'(bad), 36'd0);

    // Concurrent traffic on unrelated clocks (R8)
    do_mrst(1'b0, 2'd0, 1'b0);
    bad = 0;
    fork
      push(40, 90);
      begin
        int got = 0;
        int guard = 0;
        while (got < 40 && guard < 4000) begin
          @(negedge rclk);
          guard++;
          if (!out_flag) begin
            rd_en = 1'b1;
            @(negedge rclk) rd_en = 1'b0;
            if (rd_data != pat(90, got)) bad++;
            got++;
          end
        end
        if (got != 40) bad += 40 - got;
      end
    join
    chk(bad == 0, "R8 concurrent order", 36'(bad), 36'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule